// File: doc/BRIEF.md
# Burst ROM Access Controller

This block drives the external bus for one memory region that holds code in a 16-bit ROM able to return consecutive words quickly. The CPU issues word reads. Each read carries an address and a flag that marks it as an instruction fetch or a data read. The controller turns each read into ROM bus states and returns the word with a one-cycle ready pulse. One bus state is one clock cycle.

When burst mode is off, every read is a full access. Its length is set by the access-state setting. The region can also be narrowed to an 8-bit bus, in which case one word is assembled from two byte accesses. When burst mode is on, the region is always handled as 16 bits wide. A fetch that opens a sequence still gets a full access. After that, each further fetch that asks for the next word of the same aligned 4- or 8-word block is served with a short burst cycle of one or two states. Wait requests are not honoured in a burst cycle, and chip select and the read strobe stay asserted from one word to the next. A data read, an address out of sequence, a block boundary or a gap in requests closes the burst.

To continue a burst, the CPU presents its next request in the cycle where ready is high. A request made later finds the bus idle and starts a new full access.

Top module: `burst_rom_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `rom_cs`, `rom_rd` and `cpu_rdy` are low.
- R2: With `cfg_ast3`=0 a full access lasts 2 states. `cpu_rdy` is high for exactly the last state, with `cpu_rdata` equal to `rom_data` and `rom_addr` equal to the word address with bit 0 cleared.
- R3: With `cfg_ast3`=1 a full access lasts 3 states. `rom_wait` is sampled at the end of the second state and again at the end of every wait state it causes, and each sample taken high adds one state.
- R4: With `cfg_ast3`=0, `rom_wait` has no effect on the length of a full access.
- R5: With `cfg_burst_en`=1, a fetch that follows a fetch, is presented in its ready cycle and asks for the next word of the same aligned block is a burst cycle. It lasts 1 state when `cfg_burst_slow`=0 and 2 states when it is 1, and `rom_wait` has no effect on it.
- R6: The aligned block is 4 words (8 bytes) when `cfg_burst_long`=0 and 8 words (16 bytes) when it is 1. The block size is taken at the full access that opens the burst. A fetch into the next block gets a full access.
- R7: A data read (`cpu_fetch`=0) always gets a full access. It closes the burst, so the fetch after it also gets a full access.
- R8: A fetch whose address is not the next word, such as a repeat, a skip or a backward step, gets a full access.
- R9: When no request is present in the ready cycle, `rom_cs` and `rom_rd` drop in the next cycle and the next fetch gets a full access.
- R10: `rom_cs` and `rom_rd` stay high in every state of back-to-back accesses, including the change from one burst word to the next.
- R11: With `cfg_burst_en`=0, sequential fetches all get full accesses.
- R12: With `cfg_bus8`=1 and `cfg_burst_en`=0, a word takes two full accesses: first at the even byte address, then at the odd one. Each byte is read from `rom_data[7:0]`, and the word returned is {even byte, odd byte}. With `cfg_burst_en`=1, `cfg_bus8` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, taken when idle or in a ready cycle |
| cpu_addr | input | ADDR_W | Byte address of the requested word |
| cpu_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| cpu_rdy | output | 1 | One-cycle pulse in the last state of a word |
| cpu_rdata | output | DATA_W | Word returned, valid with `cpu_rdy` |
| cfg_burst_en | input | 1 | Enables burst mode for the region |
| cfg_burst_long | input | 1 | Block size: 0 = 4 words, 1 = 8 words |
| cfg_burst_slow | input | 1 | Burst cycle length: 0 = 1 state, 1 = 2 states |
| cfg_ast3 | input | 1 | Full access length: 0 = 2 states, 1 = 3 states with waits |
| cfg_bus8 | input | 1 | 8-bit region width, used only with burst mode off |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_cs | output | 1 | ROM chip select, active high |
| rom_rd | output | 1 | ROM read strobe, active high |
| rom_wait | input | 1 | Wait request from the ROM |
| rom_data | input | DATA_W | ROM read data |

## Verification
The hardest condition to reach from the ports is a burst continuation. The next fetch must arrive in the exact cycle where ready is high, and its address must stay inside the block chosen at the burst's start. The bench therefore drives the following request on the falling edge where it sees ready, which chains accesses without a gap. It walks whole blocks from the first word to the crossing, and it starts a burst in the middle of a block so that the boundary comes early. Wait is held high through burst cycles to show that they keep their length, and the 8-bit split is checked by reading back the odd byte address.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Kind of ROM access chosen when a request is taken
  typedef enum logic {
    ACC_FULL  = 1'b0,
    ACC_BURST = 1'b1
  } acc_kind_e;

  localparam int CNT_W = 2;

  localparam logic [CNT_W-1:0] FULL_SHORT_ST = 2'd2;
  localparam logic [CNT_W-1:0] FULL_LONG_ST  = 2'd3;
  localparam logic [CNT_W-1:0] BURST_FAST_ST = 2'd1;
  localparam logic [CNT_W-1:0] BURST_SLOW_ST = 2'd2;
  // State at whose end the wait input is sampled
  localparam logic [CNT_W-1:0] WAIT_SAMPLE_ST = 2'd2;

endpackage

// File: rtl/brc_seq_check.sv
module brc_seq_check #(
  parameter int ADDR_W     = 24,
  parameter int SHORT_LOG2 = 2,
  parameter int LONG_LOG2  = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic              long_blk,
  output logic              is_next
);
  // Byte-address bits that index a word inside one block
  localparam int SHORT_SH = SHORT_LOG2 + 1;
  localparam int LONG_SH  = LONG_LOG2 + 1;

  logic [ADDR_W-1:0] word_new;
  logic [ADDR_W-1:0] word_inc;
  logic              same_blk;

  always_comb begin
    word_new = new_addr & ~ADDR_W'(1);
    word_inc = cur_addr + ADDR_W'(2);
    if (long_blk) same_blk = (word_new >> LONG_SH) == (cur_addr >> LONG_SH);
    else          same_blk = (word_new >> SHORT_SH) == (cur_addr >> SHORT_SH);
    is_next = (word_new == word_inc) && same_blk;
  end

endmodule

// File: rtl/brc_len_calc.sv
module brc_len_calc
  import brc_pkg::*;
(
  input  acc_kind_e        kind,
  input  logic             three_state,
  input  logic             slow_burst,
  output logic [CNT_W-1:0] n_states,
  output logic             wait_ok
);
  always_comb begin
    if (kind == ACC_BURST) begin
      n_states = slow_burst ? BURST_SLOW_ST : BURST_FAST_ST;
      wait_ok  = 1'b0;
    end else begin
      n_states = three_state ? FULL_LONG_ST : FULL_SHORT_ST;
      wait_ok  = three_state;
    end
  end
endmodule

// File: rtl/burst_rom_ctrl.sv
module burst_rom_ctrl
  import brc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SHORT_LOG2 = 2,
  parameter int LONG_LOG2  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  output logic              cpu_rdy,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cfg_burst_en,
  input  logic              cfg_burst_long,
  input  logic              cfg_burst_slow,
  input  logic              cfg_ast3,
  input  logic              cfg_bus8,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_cs,
  output logic              rom_rd,
  input  logic              rom_wait,
  input  logic [DATA_W-1:0] rom_data
);
  localparam int BYTE_W = DATA_W / 2;

  // Access state
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             wait_ok_q, wait_ok_d;
  logic             bus8_q, bus8_d;
  logic             ph_q, ph_d;
  logic             chain_q, chain_d;
  logic             long_q, long_d;
  logic [ADDR_W-1:0] word_q, word_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  // Registered outputs
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic             cs_q, cs_d;
  logic             rdy_q, rdy_d;

  logic             last_st, word_end, can_take, take, seq_ok, cont;
  acc_kind_e        new_kind;
  logic [CNT_W-1:0] new_len;
  logic             new_wait_ok;
  logic [ADDR_W-1:0] req_word;

  assign req_word = cpu_addr & ~ADDR_W'(1);

  brc_seq_check #(
    .ADDR_W     (ADDR_W),
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) u_seq (
    .cur_addr (word_q),
    .new_addr (cpu_addr),
    .long_blk (long_q),
    .is_next  (seq_ok)
  );

  brc_len_calc u_len (
    .kind        (new_kind),
    .three_state (cfg_ast3),
    .slow_burst  (cfg_burst_slow),
    .n_states    (new_len),
    .wait_ok     (new_wait_ok)
  );

  always_comb begin
    last_st  = busy_q && (cnt_q == len_q);
    word_end = last_st && (!bus8_q || ph_q);
    can_take = !busy_q || word_end;
    take     = can_take && cpu_req;
    cont     = take && busy_q && chain_q && cpu_fetch && cfg_burst_en && seq_ok;
    new_kind = cont ? ACC_BURST : ACC_FULL;
  end

  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    wait_ok_d = wait_ok_q;
    bus8_d    = bus8_q;
    ph_d      = ph_q;
    chain_d   = chain_q;
    long_d    = long_q;
    word_d    = word_q;
    hi_d      = hi_q;
    raddr_d   = raddr_q;
    cs_d      = cs_q;
    if (take) begin
      busy_d    = 1'b1;
      cnt_d     = CNT_W'(1);
      len_d     = new_len;
      wait_ok_d = new_wait_ok;
      bus8_d    = cfg_bus8 && !cfg_burst_en;
      ph_d      = 1'b0;
      chain_d   = cpu_fetch && cfg_burst_en;
      if (!cont) long_d = cfg_burst_long;
      word_d    = req_word;
      raddr_d   = req_word;
      cs_d      = 1'b1;
    end else if (busy_q) begin
      if (last_st) begin
        if (bus8_q && !ph_q) begin
          // even byte done: keep it, go on to the odd byte
          hi_d    = rom_data[BYTE_W-1:0];
          ph_d    = 1'b1;
          cnt_d   = CNT_W'(1);
          raddr_d = word_q | ADDR_W'(1);
        end else begin
          busy_d  = 1'b0;
          chain_d = 1'b0;
          cs_d    = 1'b0;
        end
      end else if (wait_ok_q && (cnt_q == WAIT_SAMPLE_ST) && rom_wait) begin
        cnt_d = cnt_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    rdy_d = busy_d && (cnt_d == len_d) && (!bus8_d || ph_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      wait_ok_q <= 1'b0;
      bus8_q    <= 1'b0;
      ph_q      <= 1'b0;
      chain_q   <= 1'b0;
      long_q    <= 1'b0;
      word_q    <= '0;
      hi_q      <= '0;
      raddr_q   <= '0;
      cs_q      <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      len_q     <= len_d;
      wait_ok_q <= wait_ok_d;
      bus8_q    <= bus8_d;
      ph_q      <= ph_d;
      chain_q   <= chain_d;
      long_q    <= long_d;
      word_q    <= word_d;
      hi_q      <= hi_d;
      raddr_q   <= raddr_d;
      cs_q      <= cs_d;
      rdy_q     <= rdy_d;
    end
  end

  assign rom_addr  = raddr_q;
  assign rom_cs    = cs_q;
  assign rom_rd    = cs_q;
  assign cpu_rdy   = rdy_q;
  assign cpu_rdata = bus8_q ? {hi_q, rom_data[BYTE_W-1:0]} : rom_data;

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cfg_burst_en,
  input logic              cpu_rdy,
  input logic              rom_cs,
  input logic              rom_rd,
  input logic [ADDR_W-1:0] rom_addr
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rom_cs && !rom_rd && !cpu_rdy)); // R1

  AST_RDY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |-> (rom_cs && rom_rd)); // R2

  AST_NO_RDY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rom_cs |=> !cpu_rdy); // R2

  AST_STROBES_HELD: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdy && cpu_req) |=> (rom_cs && rom_rd)); // R10

  AST_WORD_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && !cpu_rdy) |=> (rom_addr[ADDR_W-1:1] == $past(rom_addr[ADDR_W-1:1]))); // R12

  AST_BURST_WIDE_BUS: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdy && cfg_burst_en) |-> !rom_addr[0]); // R12

endmodule

bind burst_rom_ctrl brc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_req      (cpu_req),
  .cfg_burst_en (cfg_burst_en),
  .cpu_rdy      (cpu_rdy),
  .rom_cs       (rom_cs),
  .rom_rd       (rom_rd),
  .rom_addr     (rom_addr)
);

// File: tb/burst_rom_ctrl_tb.sv
module burst_rom_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_fetch = 1'b1;
  logic          cpu_rdy;
  logic [DW-1:0] cpu_rdata;
  logic          cfg_burst_en = 1'b0, cfg_burst_long = 1'b0, cfg_burst_slow = 1'b0;
  logic          cfg_ast3 = 1'b0, cfg_bus8 = 1'b0;
  logic [AW-1:0] rom_addr;
  logic          rom_cs, rom_rd;
  logic          rom_wait = 1'b0;
  logic [DW-1:0] rom_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ROM model: both byte lanes computed from the low address byte
  assign rom_data = {rom_addr[7:0] ^ 8'h96, rom_addr[7:0] ^ 8'hC3};

  burst_rom_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_fetch(cpu_fetch), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .cfg_burst_en(cfg_burst_en), .cfg_burst_long(cfg_burst_long),
    .cfg_burst_slow(cfg_burst_slow), .cfg_ast3(cfg_ast3), .cfg_bus8(cfg_bus8),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rd(rom_rd),
    .rom_wait(rom_wait), .rom_data(rom_data)
  );

  function automatic logic [DW-1:0] wd(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h96, a[7:0] ^ 8'hC3};
  endfunction

  function automatic logic [DW-1:0] bd(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hC3, (a[7:0] | 8'h01) ^ 8'hC3};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic begin_req(input logic [AW-1:0] a, input bit f);
    @(negedge clk);
    cpu_addr = a; cpu_fetch = f; cpu_req = 1'b1;
  endtask

  // Runs the access whose request is already driven; at its ready cycle
  // presents the next request (nxt=1) or drops the request.
  task automatic xfer(input int exp_k, input logic [AW-1:0] exp_ra,
                      input logic [DW-1:0] exp_d, input bit nxt,
                      input logic [AW-1:0] na, input bit nf,
                      input int wn, input bit wall, input string tag);
    int k = 0;
    bit strobes = 1'b1;
    rom_wait = wall;
    while (k < 40) begin
      @(negedge clk);
      k++;
      if (!(rom_cs && rom_rd)) strobes = 1'b0;
      if (cpu_rdy) break;
      rom_wait = wall || (k >= 2 && k < 2 + wn);
    end
    chk(k == exp_k, {tag, " states"}, k, exp_k);
    chk(cpu_rdata == exp_d, {tag, " data"}, cpu_rdata, exp_d);
    chk(rom_addr == exp_ra, {tag, " rom_addr"}, rom_addr, exp_ra);
    chk(strobes, {tag, " R10 strobes held"}, strobes, 1);
    rom_wait = 1'b0;
    if (nxt) begin
      cpu_addr = na; cpu_fetch = nf; cpu_req = 1'b1;
    end else begin
      cpu_req = 1'b0;
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(!rom_cs && !rom_rd, tag, {rom_cs, rom_rd}, 0);
  endtask

  task automatic set_cfg(input bit be, input bit lg, input bit sl, input bit a3, input bit b8);
    @(negedge clk);
    cfg_burst_en = be; cfg_burst_long = lg; cfg_burst_slow = sl;
    cfg_ast3 = a3; cfg_bus8 = b8;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rom_cs && !rom_rd && !cpu_rdy, "R1 reset outputs", {rom_cs, rom_rd, cpu_rdy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rom_cs && !cpu_rdy, "R1 after reset", {rom_cs, cpu_rdy}, 0);
  endtask

  task automatic t_no_burst();
    set_cfg(0, 0, 0, 0, 0);
    begin_req(24'h100, 1);
    xfer(2, 24'h100, wd(24'h100), 1, 24'h102, 1, 0, 0, "R2 full 2-state");
    xfer(2, 24'h102, wd(24'h102), 0, 0, 0, 0, 0, "R11 burst off stays full");
    idle_check("R9 idle strobes low");
  endtask

  task automatic t_wait_states();
    set_cfg(0, 0, 0, 1, 0);
    begin_req(24'h141, 0);
    xfer(3, 24'h140, wd(24'h140), 1, 24'h142, 0, 0, 0, "R3 3-state no wait");
    xfer(5, 24'h142, wd(24'h142), 0, 0, 0, 2, 0, "R3 two waits");
    set_cfg(0, 0, 0, 0, 0);
    begin_req(24'h150, 0);
    xfer(2, 24'h150, wd(24'h150), 0, 0, 0, 0, 1, "R4 wait ignored 2-state");
  endtask

  task automatic t_short_block();
    set_cfg(1, 0, 0, 0, 0);
    begin_req(24'h200, 1);
    xfer(2, 24'h200, wd(24'h200), 1, 24'h202, 1, 0, 0, "R5 burst opener");
    for (int i = 1; i < 4; i++) begin
      xfer(1, AW'(24'h200 + 2*i), wd(AW'(24'h200 + 2*i)), 1, AW'(24'h202 + 2*i), 1, 0, 1,
           "R5 fast burst wait ignored");
    end
    xfer(2, 24'h208, wd(24'h208), 1, 24'h20E, 1, 0, 0, "R6 4-word boundary");
    xfer(2, 24'h20E, wd(24'h20E), 1, 24'h210, 1, 0, 0, "R8 skip is full");
    xfer(2, 24'h210, wd(24'h210), 0, 0, 0, 0, 0, "R6 mid-block start crosses early");
    idle_check("R9 idle after burst");
  endtask

  task automatic t_long_block();
    set_cfg(1, 1, 1, 1, 0);
    begin_req(24'h300, 1);
    xfer(4, 24'h300, wd(24'h300), 1, 24'h302, 1, 1, 0, "R3 opener with wait");
    for (int i = 1; i < 8; i++) begin
      xfer(2, AW'(24'h300 + 2*i), wd(AW'(24'h300 + 2*i)), 1, AW'(24'h302 + 2*i), 1, 0, 1,
           "R5 slow burst 8-word");
    end
    xfer(3, 24'h310, wd(24'h310), 0, 0, 0, 0, 0, "R6 8-word boundary");
  endtask

  task automatic t_data_breaks();
    set_cfg(1, 0, 0, 0, 0);
    begin_req(24'h400, 1);
    xfer(2, 24'h400, wd(24'h400), 1, 24'h402, 0, 0, 0, "R7 fetch opener");
    xfer(2, 24'h402, wd(24'h402), 1, 24'h404, 1, 0, 0, "R7 data full");
    xfer(2, 24'h404, wd(24'h404), 1, 24'h406, 1, 0, 0, "R7 fetch after data full");
    xfer(1, 24'h406, wd(24'h406), 0, 0, 0, 0, 0, "R5 burst resumes");
  endtask

  task automatic t_nonseq();
    set_cfg(1, 1, 0, 0, 0);
    begin_req(24'h500, 1);
    xfer(2, 24'h500, wd(24'h500), 1, 24'h504, 1, 0, 0, "R8 opener");
    xfer(2, 24'h504, wd(24'h504), 1, 24'h502, 1, 0, 0, "R8 skip full");
    xfer(2, 24'h502, wd(24'h502), 1, 24'h502, 1, 0, 0, "R8 backward full");
    xfer(2, 24'h502, wd(24'h502), 1, 24'h504, 1, 0, 0, "R8 repeat full");
    xfer(1, 24'h504, wd(24'h504), 0, 0, 0, 0, 0, "R5 next word burst");
  endtask

  task automatic t_idle_gap();
    set_cfg(1, 0, 0, 0, 0);
    begin_req(24'h600, 1);
    xfer(2, 24'h600, wd(24'h600), 0, 0, 0, 0, 0, "R9 first fetch");
    idle_check("R9 strobes drop");
    begin_req(24'h602, 1);
    xfer(2, 24'h602, wd(24'h602), 0, 0, 0, 0, 0, "R9 after gap full");
  endtask

  task automatic t_bus8();
    set_cfg(0, 0, 0, 0, 1);
    begin_req(24'h700, 1);
    xfer(4, 24'h701, bd(24'h700), 1, 24'h702, 1, 0, 0, "R12 byte split");
    xfer(4, 24'h703, bd(24'h702), 0, 0, 0, 0, 0, "R12 byte split next");
    set_cfg(1, 0, 0, 0, 1);
    begin_req(24'h720, 1);
    xfer(2, 24'h720, wd(24'h720), 1, 24'h722, 1, 0, 0, "R12 width ignored in burst");
    xfer(1, 24'h722, wd(24'h722), 0, 0, 0, 0, 0, "R12 burst 16-bit");
  endtask

  initial begin
    t_reset();
    t_no_burst();
    t_wait_states();
    t_short_block();
    t_long_block();
    t_data_breaks();
    t_nonseq();
    t_idle_gap();
    t_bus8();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule